// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Source Select

The block picks one of ten tick sources, all strobes in one system clock domain, and turns the chosen stream into a slower peripheral clock-enable strobe. The rate is set by a divider that has an integer part and a fraction. Every selected source tick adds 2^FRAC_W to a phase accumulator. When the accumulator reaches the divider value, the block emits one output tick and takes the divider value off the accumulator. Over a long run the output rate is therefore the source rate times 2^FRAC_W divided by the divider value.

Each instance sets the widths of the integer and fractional fields through parameters (INT_W and FRAC_W), with INT_W up to 20 and FRAC_W up to 12. When both widths are zero, the instance has no divider at all and passes the selected source straight through. A control word carries the run enable and the source select. The block reports a busy bit that follows the enable.

Top module: `cmux_frac_div`

## Requirements
- R1: While rst_ni is low, tick_o and busy_o are 0.
- R2: busy_o equals the enable bit (ctrl_i bit 4) as it was one clock earlier.
- R3: While the enable bit is 0, tick_o stays 0 and the accumulator is zero. After the enable is set again, the first output tick comes on the ceil(D/2^FRAC_W)-th selected source tick, where D is the divider value.
- R4: The source select is ctrl_i[3:0]. Value 0 is ground and never ticks, values 1 to 9 take src_tick_i[n], and values 10 to 15 also act as ground. src_tick_i[0] has no effect, and neither do ticks on sources that are not selected.
- R5: An output tick appears on the clock after the selected source tick that caused it. There is at most one output tick per source tick.
- R6: The divider value D is div_i[12+INT_W-1 : 12-FRAC_W]: the integer part starts at bit 12 and the fraction sits just below it. Bits of div_i outside this field have no effect.
- R7: When D is 0, tick_o stays 0.
- R8: Starting from a cleared accumulator, with D greater than 2^FRAC_W, N selected source ticks give exactly floor(N*2^FRAC_W/D) output ticks.
- R9: When D is not 0 and D is at most 2^FRAC_W, every selected source tick gives one output tick.
- R10: In any cycle where the source select or D differs from its value in the previous cycle, the source tick of that cycle is dropped and the accumulator restarts from zero.
- R11: With INT_W = FRAC_W = 0, div_i is ignored and tick_o is the enable ANDed with the selected source tick, delayed one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 10 | Source tick strobes; bit 0 is ignored (ground) |
| ctrl_i | input | 32 | Bits [3:0] select the source, bit 4 is the enable; all other bits are ignored |
| div_i | input | 32 | Divide word; the field position is given in R6 |
| busy_o | output | 1 | Enable bit, registered |
| tick_o | output | 1 | Output clock-enable strobe |

## Verification
The assertions take for granted that the configuration inputs are clean synchronous levels. They also assume each source strobe is a one-cycle pulse that is only counted while the select field names that source. The R10 property relies on the previous cycle's configuration having been sampled after reset. The stimulus therefore changes the control and divide words only at idle points and waits two clocks before pumping ticks. The sources are pulsed one cycle high and one cycle low, so every count has a known starting accumulator of zero.

// File: rtl/cmux_pkg.sv
package cmux_pkg;
  localparam int NUM_SRC = 10;
  localparam int SEL_W   = 4;
  localparam int EN_BIT  = 4;
  localparam int INT_LSB = 12;
  localparam int WORD_W  = 32;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic en;
    sel_t sel;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.en  = w[EN_BIT];
    c.sel = w[SEL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/cmux_src_pick.sv
module cmux_src_pick
  import cmux_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0] src_i,
  input  sel_t         sel_i,
  output logic         tick_o
);
  logic unused_gnd;
  assign unused_gnd = src_i[0];

  // index 0 and out-of-range selects read as ground
  always_comb begin
    tick_o = 1'b0;
    for (int k = 1; k < N; k++) begin
      if (sel_i == SEL_W'(k)) tick_o = src_i[k];
    end
  end
endmodule

// File: rtl/cmux_div_field.sv
module cmux_div_field
  import cmux_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int DIV_W = INT_W + FRAC_W
) (
  input  logic [WORD_W-1:0] div_i,
  output logic [DIV_W-1:0]  val_o,
  output logic              zero_o
);
  localparam int LSB = INT_LSB - FRAC_W;

  logic unused_word;
  assign unused_word = ^div_i;

  assign val_o  = div_i[LSB +: DIV_W];
  assign zero_o = (val_o == '0);
endmodule

// File: rtl/cmux_cfg_watch.sv
module cmux_cfg_watch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  output logic         chg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  assign chg_o = (cfg_i != cfg_q);
endmodule

// File: rtl/cmux_frac_acc.sv
module cmux_frac_acc #(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             src_tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int AW = DIV_W + 1;
  localparam logic [AW-1:0] STEP = AW'(1) << FRAC_W;

  logic [DIV_W-1:0] acc_q;
  logic [AW-1:0]    sum, rem, div_x;
  logic             hit;

  assign div_x = {1'b0, div_i};
  assign sum   = {1'b0, acc_q} + STEP;
  assign hit   = (sum >= div_x);
  assign rem   = sum - div_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (!run_i || clr_i || div_i == '0) begin
        acc_q <= '0;
      end else if (src_tick_i) begin
        if (hit) begin
          tick_o <= 1'b1;
          // divider below one: residue would overflow a single strobe
          acc_q  <= (rem >= div_x) ? '0 : rem[DIV_W-1:0];
        end else begin
          acc_q <= sum[DIV_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/cmux_frac_div.sv
module cmux_frac_div
  import cmux_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [WORD_W-1:0]  ctrl_i,
  input  logic [WORD_W-1:0]  div_i,
  output logic               busy_o,
  output logic               tick_o
);
  localparam int DIV_W = INT_W + FRAC_W;

  ctrl_t ctrl;
  logic  sel_tick;
  logic  unused_ctrl;

  assign ctrl        = unpack_ctrl(ctrl_i);
  assign unused_ctrl = ^ctrl_i;

  cmux_src_pick #(.N(NUM_SRC)) i_pick (
    .src_i  (src_tick_i),
    .sel_i  (ctrl.sel),
    .tick_o (sel_tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_o <= 1'b0;
    else         busy_o <= ctrl.en;
  end

  if (DIV_W == 0) begin : g_pass
    logic unused_div;
    assign unused_div = ^div_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_o <= 1'b0;
      else         tick_o <= ctrl.en & sel_tick;
    end
  end else begin : g_div
    logic [DIV_W-1:0] div_val;
    logic             div_zero;
    logic             cfg_chg;

    cmux_div_field #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_field (
      .div_i  (div_i),
      .val_o  (div_val),
      .zero_o (div_zero)
    );

    cmux_cfg_watch #(.W(SEL_W + DIV_W)) i_watch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  ({ctrl.sel, div_val}),
      .chg_o  (cfg_chg)
    );

    cmux_frac_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_acc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (ctrl.en & ~div_zero),
      .clr_i      (cfg_chg),
      .src_tick_i (sel_tick),
      .div_i      (div_val),
      .tick_o     (tick_o)
    );
  end
endmodule

// File: rtl/cmux_frac_div_chk.sv
module cmux_frac_div_chk
  import cmux_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_tick_i,
  input logic [WORD_W-1:0]  ctrl_i,
  input logic [WORD_W-1:0]  div_i,
  input logic               busy_o,
  input logic               tick_o
);
  localparam int DIV_W = INT_W + FRAC_W;

  logic past_ok;
  logic src_seen;
  logic dz;
  logic cfg_moved;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    src_seen = 1'b0;
    for (int k = 1; k < NUM_SRC; k++) begin
      if (ctrl_i[SEL_W-1:0] == SEL_W'(k)) src_seen = src_tick_i[k];
    end
  end

  if (DIV_W > 0) begin : g_div
    logic [SEL_W+DIV_W-1:0] seen_q;
    logic [SEL_W+DIV_W-1:0] seen_d;
    assign seen_d = {ctrl_i[SEL_W-1:0], div_i[INT_LSB-FRAC_W +: DIV_W]};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= '0;
      else         seen_q <= seen_d;
    end
    assign dz        = (div_i[INT_LSB-FRAC_W +: DIV_W] == '0);
    assign cfg_moved = past_ok && (seen_d != seen_q);
  end else begin : g_pass
    assign dz        = 1'b0;
    assign cfg_moved = 1'b0;
  end

  assert_busy_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> busy_o == $past(ctrl_i[EN_BIT]));

  assert_idle_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(ctrl_i[EN_BIT]) |-> !tick_o);

  assert_tick_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && tick_o |-> $past(src_seen));

  assert_zero_div_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(dz) |-> !tick_o);

  assert_change_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_moved |=> !tick_o);
endmodule

bind cmux_frac_div cmux_frac_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_tick_i (src_tick_i),
  .ctrl_i     (ctrl_i),
  .div_i      (div_i),
  .busy_o     (busy_o),
  .tick_o     (tick_o)
);

// File: tb/test_cmux_frac_div.sv
module test_cmux_frac_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [9:0]  src_tick_i = '0;
  logic [31:0] ctrl_i = '0;
  logic [31:0] div_i = '0;
  logic        busy_o, tick_o, busy_pt, tick_pt;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  cmux_frac_div #(.INT_W(8), .FRAC_W(4)) i_cmux_frac_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_tick_i(src_tick_i),
    .ctrl_i(ctrl_i), .div_i(div_i), .busy_o(busy_o), .tick_o(tick_o)
  );

  cmux_frac_div #(.INT_W(0), .FRAC_W(0)) i_cmux_frac_div_pt (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_tick_i(src_tick_i),
    .ctrl_i(ctrl_i), .div_i(div_i), .busy_o(busy_pt), .tick_o(tick_pt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkdiv(input int ip, input int fp, input logic [31:0] junk);
    return (junk & 32'hFFF0_00FF) | (32'(ip) << 12) | (32'(fp) << 8);
  endfunction

  // one clock: drive, then observe at the following falling edge
  task automatic cyc(input logic [9:0] s);
    src_tick_i = s;
    @(negedge clk_i);
  endtask

  task automatic set(input logic en, input int sel, input logic [31:0] d);
    ctrl_i = {27'b0, en, 4'(sel)};
    div_i  = d;
    cyc('0);
    cyc('0);
  endtask

  task automatic pump(input logic [9:0] pat, input int n, output int got, output int got_pt);
    got = 0; got_pt = 0;
    for (int i = 0; i < n; i++) begin
      cyc(pat); got += int'(tick_o); got_pt += int'(tick_pt);
      cyc('0);  got += int'(tick_o); got_pt += int'(tick_pt);
    end
  endtask

  task automatic t_reset;
    chk("R1 tick_o in reset", int'(tick_o), 0);
    chk("R1 busy_o in reset", int'(busy_o), 0);
    chk("R1 pass tick in reset", int'(tick_pt), 0);
  endtask

  task automatic t_busy;
    ctrl_i = 32'h10; cyc('0);
    chk("R2 busy set", int'(busy_o), 1);
    chk("R2 busy set pass", int'(busy_pt), 1);
    ctrl_i = 32'h0; cyc('0);
    chk("R2 busy clear", int'(busy_o), 0);
  endtask

  task automatic t_enable;
    int g, gp;
    set(1'b1, 1, mkdiv(3, 4, 0));
    pump(10'h002, 3, g, gp); chk("R3 no tick before 4th", g, 0);
    pump(10'h002, 1, g, gp); chk("R3 tick on 4th", g, 1);
    set(1'b0, 1, mkdiv(3, 4, 0));
    pump(10'h002, 20, g, gp); chk("R3 silent when off", g, 0);
    set(1'b1, 1, mkdiv(3, 4, 0));
    pump(10'h002, 3, g, gp); chk("R3 restart from zero", g, 0);
    pump(10'h002, 1, g, gp); chk("R3 restart tick", g, 1);
  endtask

  task automatic t_select;
    int g, gp;
    set(1'b1, 0, mkdiv(1, 0, 0));
    pump(10'h3FF, 10, g, gp); chk("R4 select 0 ground", g, 0);
    set(1'b1, 12, mkdiv(1, 0, 0));
    pump(10'h3FF, 10, g, gp); chk("R4 select 12 ground", g, 0);
    set(1'b1, 9, mkdiv(1, 0, 0));
    pump(10'h1FF, 10, g, gp); chk("R4 other sources ignored", g, 0);
    pump(10'h200, 10, g, gp); chk("R4 source 9 used", g, 10);
  endtask

  task automatic t_latency;
    set(1'b1, 5, mkdiv(1, 0, 0));
    cyc(10'h020);
    chk("R5 tick one clock later", int'(tick_o), 1);
    cyc('0);
    chk("R5 single strobe", int'(tick_o), 0);
  endtask

  task automatic t_ratio;
    int g, gp;
    set(1'b1, 2, mkdiv(3, 4, 0));
    pump(10'h004, 200, g, gp); chk("R8 D=52 N=200", g, 61);
    set(1'b1, 2, mkdiv(1, 8, 0));
    pump(10'h004, 150, g, gp); chk("R8 D=24 N=150", g, 100);
    set(1'b1, 2, mkdiv(5, 0, 0));
    pump(10'h004, 100, g, gp); chk("R8 D=80 N=100", g, 20);
  endtask

  task automatic t_field;
    int g, gp;
    set(1'b1, 3, mkdiv(3, 4, 32'hABC0_00FF));
    pump(10'h008, 200, g, gp); chk("R6 outer bits ignored", g, 61);
    set(1'b1, 3, mkdiv(0, 0, 32'hFFF0_00FF));
    pump(10'h008, 30, g, gp); chk("R7 zero divider silent", g, 0);
  endtask

  task automatic t_small;
    int g, gp;
    set(1'b1, 4, mkdiv(0, 10, 0));
    pump(10'h010, 30, g, gp); chk("R9 divider below one", g, 30);
  endtask

  task automatic t_change;
    int g, gp;
    set(1'b1, 1, mkdiv(3, 4, 0));
    pump(10'h002, 3, g, gp);
    set(1'b1, 1, mkdiv(3, 5, 0));
    pump(10'h002, 3, g, gp); chk("R10 div change clears", g, 0);
    pump(10'h002, 1, g, gp); chk("R10 div change tick", g, 1);
    set(1'b1, 1, mkdiv(3, 4, 0));
    pump(10'h002, 3, g, gp);
    set(1'b1, 2, mkdiv(3, 4, 0));
    pump(10'h004, 3, g, gp); chk("R10 select change clears", g, 0);
    pump(10'h004, 1, g, gp); chk("R10 select change tick", g, 1);
  endtask

  task automatic t_pass;
    int g, gp;
    set(1'b1, 3, 32'h0);
    pump(10'h008, 25, g, gp);
    chk("R11 pass every tick", gp, 25);
    set(1'b0, 3, 32'hFFFF_FFFF);
    pump(10'h008, 10, g, gp);
    chk("R11 pass off", gp, 0);
    set(1'b1, 7, 32'h1234_5678);
    pump(10'h080, 12, g, gp);
    chk("R11 div ignored", gp, 12);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_busy();
    t_enable();
    t_select();
    t_latency();
    t_ratio();
    t_field();
    t_small();
    t_change();
    t_pass();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule